// File: doc/BRIEF.md
# Flash Bus Cycle Decoder

This block is the device-side front end of a multiplexed asynchronous flash bus. Chip enable, command latch, address latch, write strobe and read strobe arrive as pins with no relation to the system clock. A parameterised chain of flip-flops brings them into the clock domain, and the block classifies every rising edge of the write strobe. Each edge is a command, address or data-input cycle. It may also be an illegal cycle or one that must be ignored. For each accepted cycle the block gives the internal logic a one-clock strobe carrying the cycle kind, the low byte and, for wide-bus data, the high byte.

While the die reports busy, command bytes are dropped unless they match a small parameterised bypass list. The default list holds only the status-read opcode 70h. Address and data cycles pass through regardless. In wide-bus mode a command whose upper byte is not zero is a protocol violation. A cycle with both latch enables high is illegal. Each of these two faults sets its own sticky flag. A standby indication follows chip enable high, but only while the die is idle.

Top module: `nandBusDecoder`

## Requirements
- R1: A write-strobe rising edge with chip enable low, read strobe high, command latch high and address latch low produces a command strobe: `cycValid` high for one clock, `cycKind` = 0, and `cycByte` equal to io[7:0] at the edge.
- R2: The same edge with the address latch high and the command latch low produces `cycKind` = 1. The low byte goes to `cycByte` and `cycHigh` is 0.
- R3: The same edge with both latch enables low produces `cycKind` = 2. `cycHigh` carries io[15:8] when `wideBus` = 1 and is 0 when `wideBus` = 0.
- R4: A write-strobe rising edge with chip enable high or read strobe low produces no strobe and changes no flag.
- R5: Both latch enables high on a write-strobe edge produces no strobe and sets `illegalErr`, which stays set until reset.
- R6: When `wideBus` = 1, a command whose io[15:8] is not zero is dropped and sets `upperErr`, which stays set until reset. When `wideBus` = 0 the upper byte of a command is ignored.
- R7: While `dieBusy` = 1, any command byte other than 70h is dropped. Command 70h and all address and data cycles are still delivered.
- R8: `standby` rises when synchronised chip enable is high and `dieBusy` = 0, even if a transfer was in progress. If chip enable goes high while busy, `standby` rises one clock after `dieBusy` falls. It falls when chip enable returns low.
- R9: The output strobe appears exactly SYNC_STAGES+1 rising clock edges after the write strobe rises, with SYNC_STAGES = 2 by default. It never lasts two consecutive clocks.
- R10: After reset, `cycValid`, `illegalErr` and `upperErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low, asynchronous |
| cle | input | 1 | Command latch enable, asynchronous |
| ale | input | 1 | Address latch enable, asynchronous |
| weN | input | 1 | Write strobe, active low, asynchronous |
| reN | input | 1 | Read strobe, active low, asynchronous |
| io | input | 16 | Multiplexed bus, asynchronous |
| wideBus | input | 1 | 1 selects the 16-bit data bus |
| dieBusy | input | 1 | Die busy, synchronous to clk |
| cycValid | output | 1 | One-clock cycle strobe |
| cycKind | output | 2 | 0 = command, 1 = address, 2 = data input |
| cycByte | output | 8 | Low byte of the cycle |
| cycHigh | output | 8 | High data byte (wide data cycles only) |
| illegalErr | output | 1 | Sticky: both latch enables high |
| upperErr | output | 1 | Sticky: non-zero upper byte on a wide command |
| standby | output | 1 | Device in standby |

## Verification
Pin changes pass through two synchroniser flops, one edge-detect flop and the output register. A cycle strobe is therefore due on the third rising clock after the write strobe rises. The bench drives that edge on a falling clock edge, counts three rising edges, and samples on the next falling edge. It samples one clock later as well, to confirm the pulse is a single cycle. Standby takes the same three-edge path for chip enable but only one edge for `dieBusy`, and the standby checks sample at those distances.

// File: rtl/nandBusPkg.sv
package nandBusPkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2
  } cycKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     emit;
    cycKind_t kind;
    logic     flagIllegal;
    logic     flagUpper;
  } ctrlStrobe_t;

  // scan a packed opcode list, used by checks outside the decode path
  function automatic logic opInList(input logic [7:0] op,
                                    input logic [63:0] list,
                                    input int count);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < count && i < 8; i++) begin
      if (list[i*8 +: 8] == op) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/nandSync.sv
module nandSync #(
  parameter int             WIDTH   = 8,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= RST_VAL;
          else       chain[0] <= dIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/nandCycleCtrl.sv
module nandCycleCtrl
  import nandBusPkg::*;
#(
  parameter int                     BYTE_W     = 8,
  parameter int                     N_BYPASS   = 1,
  parameter logic [N_BYPASS*8-1:0]  BYPASS_OPS = 8'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceS,
  input  logic              cleS,
  input  logic              aleS,
  input  logic              weS,
  input  logic              reS,
  input  logic [BYTE_W-1:0] loByte,
  input  logic              hiNonzero,
  input  logic              wideBus,
  input  logic              dieBusy,
  output ctrlStrobe_t       ctrl,
  output logic              standby
);

  logic weLast;
  logic weRise;
  logic selected;
  logic isIllegal;
  logic upperBad;
  logic busyDrop;
  logic bypassHit;
  logic [N_BYPASS-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) weLast <= 1'b1;
    else       weLast <= weS;
  end

  assign weRise   = weS & ~weLast;
  assign selected = weRise & ~ceS & reS;

  generate
    for (genvar i = 0; i < N_BYPASS; i++) begin : gBypass
      assign hitVec[i] = (loByte[7:0] == BYPASS_OPS[i*8 +: 8]);
    end
  endgenerate
  assign bypassHit = |hitVec;

  assign isIllegal = cleS & aleS;
  assign upperBad  = wideBus & cleS & ~aleS & hiNonzero;
  assign busyDrop  = cleS & ~aleS & dieBusy & ~bypassHit;

  always_comb begin
    ctrl             = '0;
    ctrl.emit        = selected & ~isIllegal & ~upperBad & ~busyDrop;
    ctrl.flagIllegal = selected & isIllegal;
    ctrl.flagUpper   = selected & upperBad;
    if (cleS)      ctrl.kind = KIND_CMD;
    else if (aleS) ctrl.kind = KIND_ADDR;
    else           ctrl.kind = KIND_DATA;
  end

  // standby: held once entered, entered only while idle
  always_ff @(posedge clk) begin
    if (!rstN) standby <= 1'b0;
    else       standby <= ceS & (~dieBusy | standby);
  end

  assert_standby_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(standby) |-> !$past(dieBusy));

  assert_standby_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (standby && !ceS) |=> !standby);

  assert_no_emit_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.emit && (ctrl.flagIllegal || ctrl.flagUpper)));

endmodule

// File: rtl/nandCycleData.sv
module nandCycleData
  import nandBusPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic [BYTE_W-1:0] loByte,
  input  logic [BYTE_W-1:0] hiByte,
  input  logic              wideBus,
  output logic              cycValid,
  output logic [1:0]        cycKind,
  output logic [BYTE_W-1:0] cycByte,
  output logic [BYTE_W-1:0] cycHigh,
  output logic              illegalErr,
  output logic              upperErr
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycValid <= 1'b0;
      cycKind  <= KIND_CMD;
      cycByte  <= '0;
      cycHigh  <= '0;
    end else begin
      cycValid <= ctrl.emit;
      if (ctrl.emit) begin
        cycKind <= ctrl.kind;
        cycByte <= loByte;
        cycHigh <= (ctrl.kind == KIND_DATA && wideBus) ? hiByte : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      illegalErr <= 1'b0;
      upperErr   <= 1'b0;
    end else begin
      if (ctrl.flagIllegal) illegalErr <= 1'b1;
      if (ctrl.flagUpper)   upperErr   <= 1'b1;
    end
  end

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |=> !cycValid);

  assert_illegal_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    illegalErr |=> illegalErr);

  assert_upper_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    upperErr |=> upperErr);

  assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |-> cycKind != 2'd3);

endmodule

// File: rtl/nandBusDecoder.sv
module nandBusDecoder
  import nandBusPkg::*;
#(
  parameter int                    BYTE_W      = 8,
  parameter int                    SYNC_STAGES = 2,
  parameter int                    N_BYPASS    = 1,
  parameter logic [N_BYPASS*8-1:0] BYPASS_OPS  = 8'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              cle,
  input  logic              ale,
  input  logic              weN,
  input  logic              reN,
  input  logic [2*BYTE_W-1:0] io,
  input  logic              wideBus,
  input  logic              dieBusy,
  output logic              cycValid,
  output logic [1:0]        cycKind,
  output logic [BYTE_W-1:0] cycByte,
  output logic [BYTE_W-1:0] cycHigh,
  output logic              illegalErr,
  output logic              upperErr,
  output logic              standby
);

  localparam int PIN_W = 5 + 2*BYTE_W;
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, {(2*BYTE_W){1'b0}}};

  logic [PIN_W-1:0]  pinsRaw;
  logic [PIN_W-1:0]  pinsSync;
  logic              ceS, cleS, aleS, weS, reS;
  logic [BYTE_W-1:0] loByte, hiByte;
  ctrlStrobe_t       ctrl;

  assign pinsRaw = {ceN, cle, ale, weN, reN, io};

  nandSync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) uSync (
    .clk(clk), .rstN(rstN), .dIn(pinsRaw), .dOut(pinsSync)
  );

  assign {ceS, cleS, aleS, weS, reS, hiByte, loByte} = pinsSync;

  nandCycleCtrl #(.BYTE_W(BYTE_W), .N_BYPASS(N_BYPASS), .BYPASS_OPS(BYPASS_OPS)) uCtrl (
    .clk(clk), .rstN(rstN), .ceS(ceS), .cleS(cleS), .aleS(aleS), .weS(weS), .reS(reS),
    .loByte(loByte), .hiNonzero(|hiByte), .wideBus(wideBus), .dieBusy(dieBusy),
    .ctrl(ctrl), .standby(standby)
  );

  nandCycleData #(.BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loByte(loByte), .hiByte(hiByte),
    .wideBus(wideBus), .cycValid(cycValid), .cycKind(cycKind), .cycByte(cycByte),
    .cycHigh(cycHigh), .illegalErr(illegalErr), .upperErr(upperErr)
  );

  assert_busy_filter_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycKind == KIND_CMD && $past(dieBusy))
      |-> opInList(cycByte[7:0], 64'(BYPASS_OPS), N_BYPASS));

  assert_narrow_high_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !wideBus && $past(!wideBus)) |-> cycHigh == '0);

endmodule

// File: tb/nandBusDecoder_test.sv
module nandBusDecoder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, cle = 1'b0, ale = 1'b0, weN = 1'b1, reN = 1'b1;
  logic [15:0] io = '0;
  logic wideBus = 1'b0, dieBusy = 1'b0;
  logic cycValid, illegalErr, upperErr, standby;
  logic [1:0] cycKind;
  logic [7:0] cycByte, cycHigh;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;
  bit expIll, expUp;

  always #2 clk = ~clk;

  nandBusDecoder uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .io(io), .wideBus(wideBus), .dieBusy(dieBusy), .cycValid(cycValid),
    .cycKind(cycKind), .cycByte(cycByte), .cycHigh(cycHigh),
    .illegalErr(illegalErr), .upperErr(upperErr), .standby(standby)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    ceN = 1'b1; cle = 0; ale = 0; weN = 1; reN = 1; io = '0; dieBusy = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expIll = 0; expUp = 0;
    @(negedge clk);
    check("R10 valid", cycValid, 0);
    check("R10 illegalErr", illegalErr, 0);
    check("R10 upperErr", upperErr, 0);
  endtask

  // one write cycle; strobe due on the third rising edge after weN rises
  task automatic busCycle(input logic c, input logic a, input logic ce,
                          input logic re, input logic [15:0] d);
    bit expV;
    logic [1:0] k;
    logic [7:0] hi;
    @(negedge clk);
    ceN = ce; cle = c; ale = a; reN = re; io = d; weN = 1'b0;
    repeat (3) @(negedge clk);
    weN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expV = !ce && re && !(c && a) && !(c && wideBus && d[15:8] != 0)
           && !(c && dieBusy && d[7:0] != 8'h70);
    if (!ce && re && c && a) expIll = 1;
    if (!ce && re && c && !a && wideBus && d[15:8] != 0) expUp = 1;
    k  = c ? 2'd0 : (a ? 2'd1 : 2'd2);
    hi = (!c && !a && wideBus) ? d[15:8] : 8'h00;
    check(c ? (dieBusy ? "R7 cmd valid" : "R1 cmd valid")
            : (a ? "R2 addr valid" : "R3 data valid"), cycValid, expV);
    if (!expV && (ce || !re)) check("R4 ignored", cycValid, 0);
    if (expV) begin
      check(c ? "R1 kind" : (a ? "R2 kind" : "R3 kind"), cycKind, k);
      check("R1 byte", cycByte, d[7:0]);
      check(wideBus ? "R3 high byte" : "R6 narrow high", cycHigh, hi);
    end
    check("R5 illegalErr", illegalErr, expIll);
    check("R6 upperErr", upperErr, expUp);
    @(negedge clk);
    check("R9 single pulse", cycValid, 0);
  endtask

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0070; pats[1] = 16'h00A5; pats[2] = 16'h3C70; pats[3] = 16'hFF0E;

    for (int w = 0; w < 2; w++) begin
      wideBus = w[0];
      doReset();
      for (int b = 0; b < 2; b++) begin
        dieBusy = b[0];
        for (int cl = 0; cl < 4; cl++)
          for (int cr = 0; cr < 4; cr++)
            for (int p = 0; p < 4; p++)
              busCycle(cl[1], cl[0], cr[1], cr[0], pats[p]);
      end
    end

    // standby: enter while idle, mid transfer
    wideBus = 0;
    doReset();
    @(negedge clk); ceN = 0; weN = 0; dieBusy = 0;
    repeat (4) @(negedge clk);
    check("R8 active", standby, 0);
    ceN = 1;
    repeat (2) @(negedge clk);
    check("R8 not yet", standby, 0);
    @(negedge clk);
    check("R8 enter idle", standby, 1);
    ceN = 0; weN = 1;
    repeat (3) @(negedge clk);
    check("R8 exit", standby, 0);
    // chip enable high while busy
    dieBusy = 1; ceN = 1;
    repeat (6) @(negedge clk);
    check("R8 held off busy", standby, 0);
    dieBusy = 0;
    @(negedge clk);
    check("R8 enter after busy", standby, 1);
    dieBusy = 1;
    repeat (2) @(negedge clk);
    check("R8 stays", standby, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule